// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast input clock, taken from the oscillator of a synthesizer loop, by a programmable ratio and emits one single-cycle pulse per divided period for the phase comparison stage. The 16-bit divisor word is split into a 4-bit swallow count A and a 12-bit main count N. In swallow mode, a 16/17 dual-modulus prescaler runs at modulus 17 until the swallow counter has been used up, and at 16 for the rest of the main count. The total ratio is therefore 16·N + A.

In direct mode, the prescaler and the swallow logic are bypassed, and the main counter divides the input by N. In high-band mode, a fixed halving stage sits ahead of the prescaler, which doubles the swallow ratio. The divisor and the mode are captured only at terminal count, so a change made mid-period never shortens or stretches the period that is running. A combinational flag reports settings that the loop should not use. The pins are plain control and status signals; no stream handshake applies to them.

Top module: `ps_divider`

## Requirements
- R1: While `srst` is high, `div_out` stays low and the divisor and mode inputs are captured. After release, in direct mode, the first pulse appears on `div_out` after N rising clock edges.
- R2: Field and mode encoding: `div_word[3:0]` is the swallow count A and `div_word[15:4]` is the main count N. `mode_sel` 2'b00 is direct, 2'b01 is swallow, and 2'b10 or 2'b11 is high-band.
- R3: In direct mode, pulses repeat every N clock cycles, and A has no effect on the period.
- R4: In swallow mode, pulses repeat every 16·N + A clock cycles.
- R5: In high-band mode, pulses repeat every 2·(16·N + A) clock cycles.
- R6: Each pulse on `div_out` is exactly one clock cycle wide.
- R7: A change to `div_word` during a period takes effect only at the next pulse. The running period keeps its old length, and the period after it uses the new value.
- R8: A change to `mode_sel` during a period also takes effect only at the next pulse.
- R9: A main count N below 2 is treated as 2.
- R10: `cfg_err` is high when N < 2, or when the mode is not direct and A ≥ N. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| srst | input | 1 | Synchronous reset, active high |
| div_word | input | 16 | Divisor: swallow count in [3:0], main count in [15:4] |
| mode_sel | input | 2 | 00 direct, 01 swallow, 1x high-band |
| div_out | output | 1 | Single-cycle pulse once per divided period |
| cfg_err | output | 1 | Illegal-setting flag for the present inputs |

## Verification
The assertions assume that `srst` is held for at least one edge before `div_out` is trusted. They also rely on the effective main count never being below 2; the clamp guarantees this even for zero or one. The single-pulse and counter-bound properties need the period to be at least two cycles, so every stimulus pattern keeps N at or above the clamp. The bench changes `div_word` and `mode_sel` only at the falling edge, and it measures a period only after one terminal count has captured the new setting. The mid-period change tests deliberately break that rule to show that the running period is unaffected.

// File: rtl/psd_pkg.sv
package psd_pkg;
  typedef enum logic [1:0] {
    MODE_DIRECT  = 2'b00,
    MODE_SWALLOW = 2'b01,
    MODE_HIGH    = 2'b10,
    MODE_HIGH_B  = 2'b11
  } div_mode_e;
endpackage

// File: rtl/ps_prescaler.sv
// Dual-modulus prescaler with optional halving stage in front.
module ps_prescaler
  import psd_pkg::*;
#(
  parameter int PRE_P = 16
) (
  input  logic      clk,
  input  logic      srst,
  input  div_mode_e mode,
  input  logic      mod_hi,
  input  logic      reload,
  output logic      pre_tick
);
  localparam int PW = $clog2(PRE_P + 2);

  logic          half_q;
  logic [PW-1:0] pc_q;
  logic [PW-1:0] last;
  logic          half_en;

  always_comb begin
    last     = mod_hi ? PW'(PRE_P) : PW'(PRE_P - 1);
    half_en  = mode[1] ? half_q : 1'b1;
    pre_tick = (mode == MODE_DIRECT) ? 1'b1 : (half_en && (pc_q == last));
  end

  always_ff @(posedge clk) begin
    if (srst || reload) begin
      half_q <= 1'b0;
      pc_q   <= '0;
    end else begin
      half_q <= ~half_q;
      if (mode != MODE_DIRECT && half_en)
        pc_q <= (pc_q == last) ? '0 : pc_q + 1'b1;
    end
  end

  // R4: the prescaler count never passes the long modulus
  a_r4_pc_bound: assert property (@(posedge clk) disable iff (srst)
    pc_q <= PW'(PRE_P));

  // R5: in high-band mode two prescaler steps never fall on adjacent cycles
  a_r5_half_rate: assert property (@(posedge clk) disable iff (srst)
    (mode[1] && pre_tick && !reload) |=> !pre_tick);
endmodule

// File: rtl/ps_counters.sv
// Swallow and main counters; terminal count reloads both.
module ps_counters #(
  parameter int SW_W   = 4,
  parameter int MAIN_W = 12
) (
  input  logic              clk,
  input  logic              srst,
  input  logic              pre_tick,
  input  logic [SW_W-1:0]   a_load,
  input  logic [MAIN_W-1:0] n_eff,
  output logic              term,
  output logic              mod_hi
);
  logic [MAIN_W-1:0] mc_q;
  logic [SW_W-1:0]   sc_q;

  always_comb begin
    term   = pre_tick && (mc_q == n_eff - 1'b1);
    mod_hi = (sc_q != '0);
  end

  always_ff @(posedge clk) begin
    if (srst || term) begin
      mc_q <= '0;
      sc_q <= a_load;
    end else if (pre_tick) begin
      mc_q <= mc_q + 1'b1;
      if (sc_q != '0) sc_q <= sc_q - 1'b1;
    end
  end

  // R9: main count stays below the effective (clamped) main count
  a_r9_mc_bound: assert property (@(posedge clk) disable iff (srst)
    mc_q < n_eff);

  // R4: swallow counter steps down once per prescaler cycle while non-zero
  a_r4_swallow_step: assert property (@(posedge clk) disable iff (srst)
    (pre_tick && !term && sc_q != '0) |=> (sc_q == $past(sc_q) - 1'b1));

  // R4: without a prescaler cycle or reload the swallow count holds
  a_r4_swallow_hold: assert property (@(posedge clk) disable iff (srst)
    (!pre_tick && !term) |=> $stable(sc_q));
endmodule

// File: rtl/ps_divider.sv
module ps_divider
  import psd_pkg::*;
#(
  parameter int SW_W   = 4,
  parameter int MAIN_W = 12,
  parameter int PRE_P  = 16,
  parameter int MIN_N  = 2
) (
  input  logic                     clk,
  input  logic                     srst,
  input  logic [SW_W+MAIN_W-1:0]   div_word,
  input  logic [1:0]               mode_sel,
  output logic                     div_out,
  output logic                     cfg_err
);
  localparam int DW = SW_W + MAIN_W;

  logic [DW-1:0]     div_q;
  div_mode_e         mode_q;
  logic [MAIN_W-1:0] n_raw, n_eff, n_in;
  logic [SW_W-1:0]   a_in;
  logic              term, mod_hi, pre_tick;

  always_comb begin
    n_raw   = div_q[DW-1:SW_W];
    n_eff   = (n_raw < MAIN_W'(MIN_N)) ? MAIN_W'(MIN_N) : n_raw;
    n_in    = div_word[DW-1:SW_W];
    a_in    = div_word[SW_W-1:0];
    cfg_err = (n_in < MAIN_W'(MIN_N)) ||
              ((mode_sel != MODE_DIRECT) && (MAIN_W'(a_in) >= n_in));
  end

  // Settings are captured only in reset or at terminal count
  always_ff @(posedge clk) begin
    if (srst || term) begin
      div_q  <= div_word;
      mode_q <= div_mode_e'(mode_sel);
    end
    div_out <= srst ? 1'b0 : term;
  end

  ps_prescaler #(.PRE_P(PRE_P)) u_pre (
    .clk      (clk),
    .srst     (srst),
    .mode     (mode_q),
    .mod_hi   (mod_hi),
    .reload   (term),
    .pre_tick (pre_tick)
  );

  ps_counters #(.SW_W(SW_W), .MAIN_W(MAIN_W)) u_cnt (
    .clk      (clk),
    .srst     (srst),
    .pre_tick (pre_tick),
    .a_load   (a_in),
    .n_eff    (n_eff),
    .term     (term),
    .mod_hi   (mod_hi)
  );

  // R6: output pulse lasts a single cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (srst)
    div_out |=> !div_out);

  // R7: captured divisor holds between terminal counts
  a_r7_div_hold: assert property (@(posedge clk) disable iff (srst)
    !term |=> $stable(div_q));

  // R8: captured mode holds between terminal counts
  a_r8_mode_hold: assert property (@(posedge clk) disable iff (srst)
    !term |=> $stable(mode_q));

  // R1: output low in the cycle after reset is sampled
  a_r1_reset_low: assert property (@(posedge clk)
    srst |=> !div_out);
endmodule

// File: tb/sim_ps_divider.sv
module sim_ps_divider;
  logic        clk = 1'b0;
  logic        srst;
  logic [15:0] div_word;
  logic [1:0]  mode_sel;
  logic        div_out;
  logic        cfg_err;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  ps_divider u0 (
    .clk(clk), .srst(srst), .div_word(div_word),
    .mode_sel(mode_sel), .div_out(div_out), .cfg_err(cfg_err)
  );

  // {mode[50:49], div[48:33], period[32:1], err[0]}
  localparam logic [50:0] VEC [0:10] = '{
    {2'b00, 16'h0050, 32'd5,    1'b0},  // R3 direct N=5
    {2'b00, 16'h0010, 32'd2,    1'b1},  // R9 N=1 clamped
    {2'b00, 16'h0000, 32'd2,    1'b1},  // R9 N=0 clamped
    {2'b01, 16'h0032, 32'd50,   1'b0},  // R4 N=3 A=2
    {2'b01, 16'h0040, 32'd64,   1'b0},  // R4 N=4 A=0
    {2'b10, 16'h0031, 32'd98,   1'b0},  // R5 N=3 A=1
    {2'b11, 16'h0021, 32'd66,   1'b0},  // R5 N=2 A=1
    {2'b01, 16'h0645, 32'd1605, 1'b0},  // R4 N=100 A=5
    {2'b01, 16'h0033, 32'd51,   1'b1},  // R10 A=N
    {2'b00, 16'h0FFF, 32'd255,  1'b0},  // R3 A ignored
    {2'b00, 16'hFFF0, 32'd4095, 1'b0}   // R3 max N
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!div_out);
  endtask

  task automatic measure(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!div_out);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #3000000;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int per;
    srst = 1'b1; div_word = 16'h0040; mode_sel = 2'b00;
    repeat (3) @(negedge clk);
    chk("R1 output low in reset", int'(div_out), 0);
    srst = 1'b0;
    per = 0;
    do begin @(negedge clk); per++; end while (!div_out);
    chk("R1 first pulse after release", per, 4);
    @(negedge clk);
    chk("R6 pulse one cycle wide", int'(div_out), 0);

    for (int i = 0; i < 11; i++) begin
      mode_sel = VEC[i][50:49];
      div_word = VEC[i][48:33];
      #1;
      chk("R10 cfg_err", int'(cfg_err), int'(VEC[i][0]));
      wait_pulse();
      measure(per);
      chk("R2/R3/R4/R5/R9 period", per, int'(VEC[i][32:1]));
      @(negedge clk);
      chk("R6 pulse one cycle wide", int'(div_out), 0);
    end

    // R7: divisor change mid-period
    mode_sel = 2'b00; div_word = 16'h0140;
    wait_pulse(); wait_pulse();
    per = 0;
    do begin
      @(negedge clk); per++;
      if (per == 5) div_word = 16'h0030;
    end while (!div_out);
    chk("R7 running period keeps old divisor", per, 20);
    measure(per);
    chk("R7 next period uses new divisor", per, 3);

    // R8: mode change mid-period
    div_word = 16'h0140;
    wait_pulse(); wait_pulse();
    per = 0;
    do begin
      @(negedge clk); per++;
      if (per == 5) begin mode_sel = 2'b01; div_word = 16'h0021; end
    end while (!div_out);
    chk("R8 running period keeps old mode", per, 20);
    measure(per);
    chk("R8 next period uses new mode", per, 33);

    // R10: direct mode with A >= N is legal
    mode_sel = 2'b00; div_word = 16'h0039; #1;
    chk("R10 direct ignores A>=N", int'(cfg_err), 0);
    mode_sel = 2'b01; #1;
    chk("R10 swallow flags A>=N", int'(cfg_err), 1);

    // R1: reset mid-run clears output
    srst = 1'b1; div_word = 16'h0020; mode_sel = 2'b00;
    repeat (4) begin
      @(negedge clk);
      chk("R1 output low in reset", int'(div_out), 0);
    end
    srst = 1'b0;
    per = 0;
    do begin @(negedge clk); per++; end while (!div_out);
    chk("R1 first pulse after release", per, 2);

    finish_run();
  end
endmodule